// File: doc/BRIEF.md
# Programmable Modulo Up/Down Counter

This block is the loop filter of a first-order, all-digital phase-locked loop. Each enabled clock moves a count register up or down by one. The direction bit comes from the loop's phase detector. When the count wraps past its top value while going up, the block raises a one-cycle carry pulse. When it wraps below zero while going down, it raises a one-cycle borrow pulse. A separate increment/decrement stage downstream uses these pulses to add or remove output edges.

The modulus is always a power of two. A small code selects it. A lower modulus gives a wide bandwidth and fast lock, and a higher modulus gives a narrow bandwidth and slow lock. The modulus code and the enable may both change while the loop runs, so the bandwidth can be tuned on the fly. Code zero parks the counter entirely. Reset is synchronous and active high.

Top module: `loop_counter`

## Requirements
- R1: A clock edge with `rst` high sets `count` to 0 and drives `carry` and `borrow` low, and these values appear in the following cycle.
- R2: A nonzero `mod_code` value n sets the modulus to 2^(n+2). Code 1 gives a modulus of 8 and code 15 gives 131072. While the code is nonzero, `count` stays within 0 to 2^(n+2)-1.
- R3: With `dir_up` high, `cnt_en` high and a nonzero code, `count` goes up by one on each clock edge until it reaches the top value.
- R4: With `dir_up` low, `cnt_en` high and a nonzero code, `count` goes down by one on each clock edge until it reaches zero.
- R5: An up step from the top value 2^(n+2)-1 sets `count` to 0 and makes `carry` high for that one cycle only.
- R6: A down step from 0 sets `count` to 2^(n+2)-1 and makes `borrow` high for that one cycle only.
- R7: While `mod_code` is 0, `count` holds its value and no carry or borrow pulse is produced, whatever `cnt_en` and `dir_up` are.
- R8: While `cnt_en` is low and the code is nonzero, the counter does not step and produces no pulse.
- R9: After `mod_code` changes, the next clock edge keeps only the low n+2 bits of `count`, and the count goes on from that masked value.
- R10: `carry` and `borrow` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Advance enable |
| dir_up | input | 1 | Direction: 1 counts up, 0 counts down |
| mod_code | input | CODE_W (4) | Modulus code; 0 inhibits |
| count | output | CNT_W (17) | Registered count value |
| carry | output | 1 | One-cycle pulse on upward wrap |
| borrow | output | 1 | One-cycle pulse on downward wrap |

## Verification
The bench builds the block with its default parameters: a 4-bit code, a minimum exponent of 3, and therefore a 17-bit count. This puts both ends of the code range within reach. Code 1 is small enough to run through complete wraps in both directions. Code 15 is reached from zero through a borrow, which loads its 131071 top value in a single step, and an up step then wraps it back with a carry. Middle codes exercise masking when the code shrinks with the enable low.

// File: rtl/lc_pkg.sv
package lc_pkg;

  // Kind of move the counter makes on the next edge
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Width needed to hold the largest modulus the code can select
  function automatic int unsigned count_width(int unsigned code_w, int unsigned min_exp);
    return min_exp + (1 << code_w) - 2;
  endfunction

endpackage

// File: rtl/lc_mod_decode.sv
module lc_mod_decode #(
  parameter int CODE_W  = 4,
  parameter int MIN_EXP = 3,
  parameter int CNT_W   = 17
) (
  input  logic [CODE_W-1:0] mod_code,
  output logic [CNT_W-1:0]  mask,
  output logic              active
);

  assign active = |mod_code;

  // Bit g belongs to the modulus when the exponent code+MIN_EXP-1 exceeds g
  for (genvar g = 0; g < CNT_W; g++) begin : g_bit
    if (g < MIN_EXP) begin : g_low
      assign mask[g] = active;
    end else begin : g_high
      assign mask[g] = (int'(mod_code) > (g - MIN_EXP + 1));
    end
  end

endmodule

// File: rtl/lc_step_select.sv
module lc_step_select
  import lc_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic             cnt_en,
  input  logic             dir_up,
  input  logic             active,
  input  logic [CNT_W-1:0] mask,
  input  logic [CNT_W-1:0] count_q,
  output step_e            step,
  output logic [CNT_W-1:0] count_d,
  output logic             wrap_up,
  output logic             wrap_dn
);

  logic [CNT_W-1:0] masked;
  logic             at_top;
  logic             at_zero;

  assign masked  = count_q & mask;
  assign at_top  = active && (masked == mask);
  assign at_zero = (masked == '0);

  always_comb begin
    step    = STEP_HOLD;
    count_d = count_q;
    wrap_up = 1'b0;
    wrap_dn = 1'b0;
    if (active) begin
      count_d = masked;
      if (cnt_en) begin
        step = dir_up ? STEP_UP : STEP_DOWN;
      end
    end
    unique case (step)
      STEP_UP: begin
        wrap_up = at_top;
        count_d = at_top ? '0 : masked + 1'b1;
      end
      STEP_DOWN: begin
        wrap_dn = at_zero;
        count_d = at_zero ? mask : masked - 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lc_count_reg.sv
module lc_count_reg #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count_d,
  input  logic             wrap_up,
  input  logic             wrap_dn,
  output logic [CNT_W-1:0] count_q,
  output logic             carry_q,
  output logic             borrow_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      carry_q  <= 1'b0;
      borrow_q <= 1'b0;
    end else begin
      count_q  <= count_d;
      carry_q  <= wrap_up;
      borrow_q <= wrap_dn;
    end
  end

endmodule

// File: rtl/loop_counter.sv
module loop_counter
  import lc_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int MIN_EXP = 3,
  localparam int CNT_W  = count_width(CODE_W, MIN_EXP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              dir_up,
  input  logic [CODE_W-1:0] mod_code,
  output logic [CNT_W-1:0]  count,
  output logic              carry,
  output logic              borrow
);

  logic [CNT_W-1:0] mask;
  logic             active;
  logic [CNT_W-1:0] count_d;
  logic             wrap_up;
  logic             wrap_dn;
  step_e            step;

  lc_mod_decode #(
    .CODE_W (CODE_W),
    .MIN_EXP(MIN_EXP),
    .CNT_W  (CNT_W)
  ) u_decode (
    .mod_code(mod_code),
    .mask    (mask),
    .active  (active)
  );

  lc_step_select #(
    .CNT_W(CNT_W)
  ) u_select (
    .cnt_en (cnt_en),
    .dir_up (dir_up),
    .active (active),
    .mask   (mask),
    .count_q(count),
    .step   (step),
    .count_d(count_d),
    .wrap_up(wrap_up),
    .wrap_dn(wrap_dn)
  );

  lc_count_reg #(
    .CNT_W(CNT_W)
  ) u_reg (
    .clk     (clk),
    .rst     (rst),
    .count_d (count_d),
    .wrap_up (wrap_up),
    .wrap_dn (wrap_dn),
    .count_q (count),
    .carry_q (carry),
    .borrow_q(borrow)
  );

endmodule

// File: rtl/lc_checker.sv
module lc_checker #(
  parameter int CODE_W  = 4,
  parameter int MIN_EXP = 3,
  parameter int CNT_W   = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_en,
  input logic              dir_up,
  input logic [CODE_W-1:0] mod_code,
  input logic [CNT_W-1:0]  count,
  input logic              carry,
  input logic              borrow
);

  logic [CNT_W-1:0] chk_mask;
  logic             in_range;
  logic             at_top;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      chk_mask[i] = (mod_code != '0) && (i < int'(mod_code) + MIN_EXP - 1);
    end
  end

  assign in_range = ((count & ~chk_mask) == '0);
  assign at_top   = (count == chk_mask);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count == '0 && !carry && !borrow));

  p_fits_modulus_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(mod_code) != '0) |-> ((count & ~$past(chk_mask)) == '0));

  p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && dir_up && mod_code != '0 && in_range && !at_top)
      |=> (count == $past(count) + 1'b1 && !carry));

  p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !dir_up && mod_code != '0 && in_range && count != '0)
      |=> (count == $past(count) - 1'b1 && !borrow));

  p_carry_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    carry |-> (count == '0 && $past(dir_up) && $past(cnt_en)));

  p_borrow_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    borrow |-> (count == $past(chk_mask) && !$past(dir_up) && $past(cnt_en)));

  p_inhibit_r7: assert property (@(posedge clk) disable iff (rst)
    (mod_code == '0) |=> ($stable(count) && !carry && !borrow));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && mod_code != '0)
      |=> (!carry && !borrow && count == ($past(count) & $past(chk_mask))));

  p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(carry && borrow));

endmodule

bind loop_counter lc_checker #(
  .CODE_W (CODE_W),
  .MIN_EXP(MIN_EXP),
  .CNT_W  (CNT_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cnt_en  (cnt_en),
  .dir_up  (dir_up),
  .mod_code(mod_code),
  .count   (count),
  .carry   (carry),
  .borrow  (borrow)
);

// File: tb/tb_loop_counter.sv
module tb_loop_counter;

  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 4;
  localparam int CNT_W      = 17;

  typedef struct {
    logic [CNT_W-1:0] cnt;
    logic             c;
    logic             b;
    string            tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cnt_en = 1'b0;
  logic              dir_up = 1'b0;
  logic [CODE_W-1:0] mod_code = '0;
  logic [CNT_W-1:0]  count;
  logic              carry;
  logic              borrow;

  exp_t        q[$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  int unsigned m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_counter dut (
    .clk     (clk),
    .rst     (rst),
    .cnt_en  (cnt_en),
    .dir_up  (dir_up),
    .mod_code(mod_code),
    .count   (count),
    .carry   (carry),
    .borrow  (borrow)
  );

  // Driver: apply one cycle of stimulus and push the modelled result
  task automatic step(input bit r, input bit e, input bit u, input int code, input string tag);
    exp_t        x;
    int unsigned modv;
    int unsigned c;
    @(negedge clk);
    rst      = r;
    cnt_en   = e;
    dir_up   = u;
    mod_code = CODE_W'(code);
    x.c = 1'b0;
    x.b = 1'b0;
    if (r) begin
      m_cnt = 0;
    end else if (code != 0) begin
      modv = 32'd1 << (code + 2);
      c    = m_cnt % modv;
      if (!e) begin
        m_cnt = c;
      end else if (u) begin
        if (c == modv - 1) begin m_cnt = 0; x.c = 1'b1; end
        else m_cnt = c + 1;
      end else begin
        if (c == 0) begin m_cnt = modv - 1; x.b = 1'b1; end
        else m_cnt = c - 1;
      end
    end
    x.cnt = CNT_W'(m_cnt);
    x.tag = tag;
    q.push_back(x);
  endtask

  // Monitor: compare after each edge once outputs have settled
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() != 0) begin
        exp_t x;
        x = q.pop_front();
        checks++;
        if (count !== x.cnt || carry !== x.c || borrow !== x.b) begin
          errors++;
          $display("FAIL %s: count=%0d carry=%0b borrow=%0b expected count=%0d carry=%0b borrow=%0b",
                   x.tag, count, carry, borrow, x.cnt, x.c, x.b);
        end
        // R10: pulses are mutually exclusive
        checks++;
        if (carry === 1'b1 && borrow === 1'b1) begin
          errors++;
          $display("FAIL R10: carry=%0b borrow=%0b expected not both high", carry, borrow);
        end
      end
    end
  end

  initial begin
    // R1: reset state
    step(1, 0, 0, 0, "R1");
    step(1, 1, 1, 1, "R1");
    // R2/R3/R5: modulus 8 counting up through a wrap
    for (int i = 0; i < 10; i++) step(0, 1, 1, 1, "R3_R5_R2");
    // R4/R6: counting down through zero with modulus 8
    for (int i = 0; i < 5; i++) step(0, 1, 0, 1, "R4_R6");
    // R7: code 0 inhibits in both directions
    for (int i = 0; i < 4; i++) step(0, 1, i[0], 0, "R7");
    // R8: enable low holds
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, "R8");
    // R9: count to 20 with modulus 32, then shrink to modulus 8 with enable low
    step(1, 0, 0, 3, "R1");
    for (int i = 0; i < 20; i++) step(0, 1, 1, 3, "R3");
    step(0, 0, 1, 1, "R9");
    step(0, 1, 1, 1, "R9");
    // R2: largest modulus reached through a borrow, then wrapped back by a carry
    step(1, 0, 0, 15, "R1");
    step(0, 1, 0, 15, "R6_R2");
    step(0, 1, 0, 15, "R4");
    step(0, 1, 1, 15, "R3");
    step(0, 1, 1, 15, "R5_R2");
    // R5: full cycle with modulus 16
    for (int i = 0; i < 17; i++) step(0, 1, 1, 2, "R5");
    // R1: reset in the middle of a count
    step(1, 1, 1, 2, "R1");
    step(0, 0, 1, 2, "R8");
    @(negedge clk);
    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule